// File: doc/BRIEF.md
# Buffered Baud Rate Generator

This block makes the oversampling strobe for a serial port. A CPU programs a 13-bit modulo divisor over a simple byte-wide register bus. The divisor is split across two registers: a high register and a low register. The block emits a one-cycle pulse once every divisor-count bus clocks, which is sixteen times the wanted bit rate. A receiver or transmitter samples and shifts on this pulse.

A write to the high register does not change the working divisor at once. The block parks the new upper divisor bits in a staging buffer. They join the working divisor only when the low register is next written, so the divisor never takes a half-updated value. The same low-register write restarts the count, so the first pulse at the new rate comes a full period after the write.

The high register also holds two interrupt-enable bits, for break detection and for a receive-line edge. These bits are stored, read back and brought out as outputs. A divisor of zero stops the counter to save power. After reset the counter stays stopped until the receive enable or the transmit enable is first raised. From then on it runs whatever those enables do.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the high register (offset 0x40) reads 0x00, the low register (offset 0x41) reads 0x04, both interrupt-enable outputs are 0 and no tick is produced.
- R2: A read at offset 0x40 returns {break-detect enable in bit 7, line-edge enable in bit 6, 0 in bit 5, working divisor bits 12:8 in bits 4:0}. A read at offset 0x41 returns working divisor bits 7:0. Any other offset reads 0x00. Bit 5 ignores writes.
- R3: A write to offset 0x40 sets the two interrupt-enable bits from write data bits 7 and 6 at once. They are driven on brk_irq_en and edge_irq_en and read back.
- R4: A write to offset 0x40 changes only the staging buffer for divisor bits 12:8. The working divisor and the read-back value of those bits keep their old values until the low register is written.
- R5: A write to offset 0x41 loads divisor bits 7:0 from the write data and bits 12:8 from the staging buffer in the same clock edge.
- R6: With a working divisor BR from 1 to 8191 and the generator released, tick16 is high for exactly one cycle every BR cycles. With BR = 1 it is high every cycle.
- R7: A write to offset 0x41 restarts the count. Counting the write cycle as cycle 0, the next tick is high in cycle BR, even in the middle of a period.
- R8: While the working divisor is 0, tick16 stays low.
- R9: After reset tick16 stays low until rx_enable or tx_enable is 1. Counting the cycle in which the enable is first high as cycle 0, the first tick is high in cycle BR.
- R10: Once released, the generator keeps ticking when both rx_enable and tx_enable return to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| rx_enable | input | 1 | Receiver enable |
| tx_enable | input | 1 | Transmitter enable |
| brk_irq_en | output | 1 | Stored break-detect interrupt enable |
| edge_irq_en | output | 1 | Stored line-edge interrupt enable |
| tick16 | output | 1 | One-cycle pulse at sixteen times the bit rate |

## Verification
The bench reads the high register between a high write and the following low write. A design that applies the upper bits at once shows them early and would run briefly at a mixed rate. It rewrites the low register in the middle of a period and checks that the next pulse comes a full period later. A design without the restart gives a short first period. It also covers the extreme divisors 1 and 8191, a zero divisor, and the window after reset. A design with an off-by-one terminal count fails the period checks. A design that ignores the enable gating ticks before release. A design that keeps gating on the live enables stops when they drop.

// File: rtl/bgen_pkg.sv
`timescale 1ns/1ps
package bgen_pkg;
   localparam int BYTE_W    = 8;
   localparam int IE_BRK_B  = 7;
   localparam int IE_EDGE_B = 6;
   localparam int HI_SPAN   = 6;   // bits 5:0 of the high register carry divisor bits

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_HI,
      SEL_LO
   } reg_sel_e;
endpackage

// File: rtl/bgen_regs.sv
`timescale 1ns/1ps
module bgen_regs
   import bgen_pkg::*;
#(
   parameter int                ADDR_W = 8,
   parameter int                DIV_W  = 13,
   parameter logic [ADDR_W-1:0] HI_OFF = 'h40,
   parameter logic [ADDR_W-1:0] LO_OFF = 'h41,
   parameter logic [BYTE_W-1:0] RST_LO = 8'h04
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic [DIV_W-1:0]  div_value,
   output logic              div_load,
   output logic              brk_ie,
   output logic              edge_ie
);
   localparam int HI_W = DIV_W - BYTE_W;

   // elaboration-time parameter checks
   if (DIV_W <= BYTE_W || HI_W > HI_SPAN) begin : g_bad_width
      $error("bgen_regs: DIV_W must lie in 9..14");
   end
   if (HI_OFF == LO_OFF) begin : g_bad_offsets
      $error("bgen_regs: register offsets must differ");
   end

   reg_sel_e          sel;
   logic [HI_W-1:0]   stage_q;
   logic [HI_W-1:0]   work_hi_q;
   logic [BYTE_W-1:0] work_lo_q;
   logic [HI_SPAN-1:0] hi_div_rd;
   wire  unused_wbits = ^bus_wdata[HI_SPAN-1:HI_W];

   always_comb begin
      if (bus_addr == HI_OFF)      sel = SEL_HI;
      else if (bus_addr == LO_OFF) sel = SEL_LO;
      else                         sel = SEL_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q   <= '0;
         work_hi_q <= '0;
         work_lo_q <= RST_LO;
         brk_ie    <= 1'b0;
         edge_ie   <= 1'b0;
      end else if (bus_we) begin
         if (sel == SEL_HI) begin
            stage_q <= bus_wdata[HI_W-1:0];
            brk_ie  <= bus_wdata[IE_BRK_B];
            edge_ie <= bus_wdata[IE_EDGE_B];
         end else if (sel == SEL_LO) begin
            work_lo_q <= bus_wdata;
            work_hi_q <= stage_q;
         end
      end
   end

   // upper divisor bits as seen on a read; unused positions read zero
   for (genvar b = 0; b < HI_SPAN; b++) begin : g_hi_rd
      if (b < HI_W) begin : g_used
         assign hi_div_rd[b] = work_hi_q[b];
      end else begin : g_resv
         assign hi_div_rd[b] = 1'b0;
      end
   end

   always_comb begin
      case (sel)
         SEL_HI:  bus_rdata = {brk_ie, edge_ie, hi_div_rd};
         SEL_LO:  bus_rdata = work_lo_q;
         default: bus_rdata = '0;
      endcase
   end

   assign div_value = {work_hi_q, work_lo_q};
   assign div_load  = bus_we && (sel == SEL_LO);

   a_r4_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel == SEL_HI) |=> $stable(div_value));

   a_r5_commit: assert property (@(posedge clk) disable iff (!rst_n)
      div_load |=> (div_value == {$past(stage_q), $past(bus_wdata)}));

   a_r3_ie_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel == SEL_HI) |=>
         (brk_ie == $past(bus_wdata[IE_BRK_B]) && edge_ie == $past(bus_wdata[IE_EDGE_B])));
endmodule

// File: rtl/bgen_release.sv
`timescale 1ns/1ps
module bgen_release (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_en,
   input  logic tx_en,
   output logic run_ok
);
   logic released_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) released_q <= 1'b0;
      else        released_q <= released_q | rx_en | tx_en;
   end

   assign run_ok = released_q | rx_en | tx_en;

   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      run_ok |=> run_ok);
endmodule

// File: rtl/bgen_divider.sv
`timescale 1ns/1ps
module bgen_divider #(
   parameter int DIV_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_value,
   input  logic             load,
   input  logic             enable,
   output logic             tick
);
   if (DIV_W < 2) begin : g_bad_width
      $error("bgen_divider: DIV_W too small");
   end

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] term_cnt;
   logic             run;

   assign term_cnt = div_value - DIV_W'(1);
   assign run      = enable && (div_value != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (load || !run) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (cnt_q == term_cnt) begin
         cnt_q <= '0;
         tick  <= 1'b1;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
         tick  <= 1'b0;
      end
   end

   a_r8_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (div_value == '0) |=> !tick);

   a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == '0 && !tick));

   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div_value > DIV_W'(1)) |=> !tick);
endmodule

// File: rtl/baud_tick_gen.sv
`timescale 1ns/1ps
module baud_tick_gen
   import bgen_pkg::*;
#(
   parameter int                ADDR_W = 8,
   parameter int                DIV_W  = 13,
   parameter logic [ADDR_W-1:0] HI_OFF = 'h40,
   parameter logic [ADDR_W-1:0] LO_OFF = 'h41,
   parameter logic [BYTE_W-1:0] RST_LO = 8'h04
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              rx_enable,
   input  logic              tx_enable,
   output logic              brk_irq_en,
   output logic              edge_irq_en,
   output logic              tick16
);
   logic [DIV_W-1:0] div_value;
   logic             div_load;
   logic             run_ok;

   bgen_regs #(
      .ADDR_W (ADDR_W),
      .DIV_W  (DIV_W),
      .HI_OFF (HI_OFF),
      .LO_OFF (LO_OFF),
      .RST_LO (RST_LO)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .div_value (div_value),
      .div_load  (div_load),
      .brk_ie    (brk_irq_en),
      .edge_ie   (edge_irq_en)
   );

   bgen_release i_release (
      .clk    (clk),
      .rst_n  (rst_n),
      .rx_en  (rx_enable),
      .tx_en  (tx_enable),
      .run_ok (run_ok)
   );

   bgen_divider #(
      .DIV_W (DIV_W)
   ) i_divider (
      .clk       (clk),
      .rst_n     (rst_n),
      .div_value (div_value),
      .load      (div_load),
      .enable    (run_ok),
      .tick      (tick16)
   );

   a_r9_hold_until_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !run_ok |=> !tick16);
endmodule

// File: tb/test_baud_tick_gen.sv
`timescale 1ns/1ps
module test_baud_tick_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       rx_enable = 1'b0;
   logic       tx_enable = 1'b0;
   logic       brk_irq_en;
   logic       edge_irq_en;
   logic       tick16;

   int checks = 0;
   int errors = 0;

   localparam logic [7:0] A_HI = 8'h40;
   localparam logic [7:0] A_LO = 8'h41;

   always #4 clk = ~clk;   // 125 MHz

   baud_tick_gen i_baud_tick_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_we      (bus_we),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .rx_enable   (rx_enable),
      .tx_enable   (tx_enable),
      .brk_irq_en  (brk_irq_en),
      .edge_irq_en (edge_irq_en),
      .tick16      (tick16)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic do_reset();
      rst_n = 1'b0; bus_we = 1'b0; rx_enable = 1'b0; tx_enable = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   // expects a tick in cycles k where k % br == 0, k = 1..n, counted from now
   task automatic expect_ticks(input string tag, input int br, input int n);
      int bad = 0;
      int first_k = 0;
      logic first_act = 1'b0;
      for (int k = 1; k <= n; k++) begin
         @(negedge clk);
         if (tick16 !== ((k % br) == 0)) begin
            if (bad == 0) begin first_k = k; first_act = tick16; end
            bad++;
         end
      end
      checks++;
      if (bad != 0) begin
         errors++;
         $display("FAIL %s: br=%0d cycle %0d tick actual=%0b expected=%0b (%0d bad cycles)",
                  tag, br, first_k, first_act, !first_act, bad);
      end
   endtask

   task automatic expect_quiet(input string tag, input int n);
      int seen = 0;
      for (int k = 1; k <= n; k++) begin
         @(negedge clk);
         if (tick16 === 1'b1) seen++;
      end
      chk(tag, seen, 0);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      do_reset();
      rd(A_HI, v); chk("R1 high reset value", v, 8'h00);
      rd(A_LO, v); chk("R1 low reset value", v, 8'h04);
      chk("R1 ie outputs at reset", {brk_irq_en, edge_irq_en}, 2'b00);
      expect_quiet("R9 no tick before enable", 40);
   endtask

   task automatic t_release_rx();
      rx_enable = 1'b1;
      expect_ticks("R9 first tick after rx enable", 4, 16);
      rx_enable = 1'b0;
      expect_ticks("R10 ticks continue after enables drop", 4, 16);
   endtask

   task automatic t_release_tx();
      do_reset();
      expect_quiet("R9 idle before tx enable", 20);
      tx_enable = 1'b1;
      expect_ticks("R9 first tick after tx enable", 4, 12);
      tx_enable = 1'b0;
      expect_ticks("R10 ticks continue after tx drop", 4, 8);
   endtask

   task automatic t_map_ie();
      logic [7:0] v;
      rd(8'h42, v); chk("R2 unmapped offset reads zero", v, 8'h00);
      wr(A_HI, 8'hC0);
      chk("R3 ie outputs set", {brk_irq_en, edge_irq_en}, 2'b11);
      rd(A_HI, v); chk("R3 ie readback", v, 8'hC0);
      wr(A_HI, 8'h40);
      chk("R3 ie outputs partial", {brk_irq_en, edge_irq_en}, 2'b01);
      rd(A_HI, v); chk("R3 ie partial readback", v, 8'h40);
   endtask

   task automatic t_stage();
      logic [7:0] v;
      wr(A_HI, 8'h05);
      rd(A_HI, v); chk("R4 high read shows working bits", v, 8'h00);
      rd(A_LO, v); chk("R4 low unchanged by high write", v, 8'h04);
      wr(A_LO, 8'h10);
      rd(A_HI, v); chk("R5 high bits committed", v, 8'h05);
      rd(A_LO, v); chk("R5 low bits committed", v, 8'h10);
      expect_ticks("R5 period 1296 after commit", 1296, 2592);
   endtask

   task automatic t_reserved_max();
      logic [7:0] v;
      wr(A_HI, 8'h3F);
      wr(A_LO, 8'hFF);
      rd(A_HI, v); chk("R2 bit5 ignores write", v, 8'h1F);
      wr(A_HI, 8'hFF);
      rd(A_HI, v); chk("R2 high layout with ie set", v, 8'hDF);
      wr(A_LO, 8'hFF);
      expect_ticks("R6 max divisor 8191", 8191, 8191);
   endtask

   task automatic t_periods();
      int brs[4] = '{1, 2, 5, 3};
      wr(A_HI, 8'h00);
      foreach (brs[i]) begin
         wr(A_LO, 8'(brs[i]));
         expect_ticks("R6 R7 period after low write", brs[i], 24);
      end
   endtask

   task automatic t_zero();
      wr(A_HI, 8'h00);
      wr(A_LO, 8'h00);
      expect_quiet("R8 zero divisor no ticks", 60);
      wr(A_LO, 8'h03);
      expect_ticks("R8 resume after zero", 3, 12);
   endtask

   task automatic t_reload_mid();
      wr(A_LO, 8'h06);
      repeat (3) @(negedge clk);
      wr(A_LO, 8'h06);
      expect_ticks("R7 mid-period reload", 6, 18);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_release_rx();
      t_map_ie();
      t_stage();
      t_reserved_max();
      t_periods();
      t_zero();
      t_reload_mid();
      t_release_tx();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule